// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two page table entries in turn from memory through a single read port that uses a request/response handshake. The caller gives a virtual address, an access kind (read, write or execute) and a user-mode flag. The walker latches these values together with the table base address. It first reads the entry that the top ten bits of the address select in the first-level table. That entry names a second-level table. The walker then reads the entry that the next ten bits select in that second table. Only one walk is in flight at a time.

A walk ends in one of two ways. It can produce a physical address, which is the 20-bit frame number of the final entry joined to the untouched 12-bit page offset. Or it can produce a fault code. The fault code says whether the first-level entry was absent, the second-level entry was absent, or the access broke the permission flags of the final entry. The result is shown for exactly one cycle. After that the walker is ready for a new request.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `done_valid` are 0.
- R2: The first read goes to the latched `ptbr` plus four times `req_vaddr[31:22]`. The second read goes to `{first entry[31:12], 12'h000}` plus four times `req_vaddr[21:12]`.
- R3: On a successful walk, `done_valid` is high for exactly one cycle. `done_fault` is 0 and `done_paddr` equals `{second entry[31:12], req_vaddr[11:0]}`.
- R4: The layout of an entry is: bit 0 present, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, bit 4 supervisor only, and bits [31:12] frame number.
- R5: If the first-level entry has bit 0 clear, the walk ends with `done_fault` = 1 and `done_paddr` = 0. No second memory read is issued.
- R6: If the second-level entry has bit 0 clear, the walk ends with `done_fault` = 2. This code takes priority over any permission problem in that entry.
- R7: `req_acc` encodes 0 = read (needs bit 1), 1 = write (needs bit 2) and 2 = execute (needs bit 3). The code 3 is reserved. A missing permission, or the code 3, gives `done_fault` = 3.
- R8: A request with `req_user` = 1 to an entry that has bit 4 set gives `done_fault` = 3. The same access with `req_user` = 0 succeeds.
- R9: `req_ready` is 1 only while the walker is idle. A `req_valid` seen during a walk has no effect on that walk's result.
- R10: `mem_req_valid` and `mem_req_addr` stay constant until `mem_req_ready` is seen. Results are the same under any memory stall and any response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | A translation request is present |
| req_ready | output | 1 | The walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_user | input | 1 | Access is made in user mode |
| ptbr | input | 32 | Base address of the first-level table, latched when a request is accepted |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | Result is present (one cycle) |
| done_paddr | output | 32 | Physical address, or 0 on a fault |
| done_fault | output | 2 | 0 none, 1 first level absent, 2 second level absent, 3 permission |

## Verification
The hardest case to reach is the absent first-level entry. The check there concerns something that does not happen: no second read may be issued. The bench's memory model counts every accepted read whose address falls inside the second-level tables. It checks that this count does not change across walks whose first-level entry is clear. The same vector table is then run again with the memory ready line toggling and a response delay of three cycles. This shows that holding the request and waiting for the response do not change any result. One further walk is run while `req_valid` stays high with a different address, to show that the in-flight walk ignores it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_L1   = 2'd1,
        FLT_L2   = 2'd2,
        FLT_PERM = 2'd3
    } walk_flt_e;

    typedef enum logic [1:0] {
        ACC_RD   = 2'd0,
        ACC_WR   = 2'd1,
        ACC_EX   = 2'd2,
        ACC_RSVD = 2'd3
    } acc_kind_e;

    // Entry flag bits as stored in the low bits of an entry
    typedef struct packed {
        logic sup_only; // bit 4
        logic ex_ok;    // bit 3
        logic wr_ok;    // bit 2
        logic rd_ok;    // bit 1
        logic present;  // bit 0
    } ent_flags_t;

    localparam int FLAG_BITS = $bits(ent_flags_t);

endpackage

// File: rtl/ptw_entry_unpack.sv
module ptw_entry_unpack
    import ptw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic [DATA_W-1:0]           entry,
    output logic [DATA_W-PAGE_BITS-1:0] frame,
    output ent_flags_t                  flags
);
    localparam int RSVD_W = PAGE_BITS - FLAG_BITS;

    logic [RSVD_W-1:0] unused_rsvd;

    assign frame       = entry[DATA_W-1:PAGE_BITS];
    assign flags       = ent_flags_t'(entry[FLAG_BITS-1:0]);
    assign unused_rsvd = entry[PAGE_BITS-1:FLAG_BITS];
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    assign addr = base + (ADDR_W'(idx) << SHIFT);
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  ent_flags_t flags,
    input  acc_kind_e  acc,
    input  logic       user,
    output logic       allowed
);
    logic kind_ok;

    always_comb begin
        case (acc)
            ACC_RD:  kind_ok = flags.rd_ok;
            ACC_WR:  kind_ok = flags.wr_ok;
            ACC_EX:  kind_ok = flags.ex_ok;
            default: kind_ok = 1'b0;
        endcase
    end

    assign allowed = kind_ok && !(user && flags.sup_only);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 10,
    parameter int ENT_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] ptbr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_paddr,
    output logic [1:0]        done_fault
);
    localparam int FRAME_W   = ADDR_W - PAGE_BITS;
    localparam int ENT_SHIFT = $clog2(ENT_BYTES);
    localparam int HI_LSB    = PAGE_BITS + IDX_W;

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] va;
        acc_kind_e         acc;
        logic              user;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] l2_base;
        logic [ADDR_W-1:0] paddr;
        walk_flt_e         fault;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [IDX_W-1:0]  idx_hi, idx_lo;
    logic [ADDR_W-1:0] l1_addr, l2_addr;
    logic [FRAME_W-1:0] rsp_frame;
    ent_flags_t        rsp_flags;
    logic              perm_ok;

    assign idx_hi = r_q.va[HI_LSB +: IDX_W];
    assign idx_lo = r_q.va[PAGE_BITS +: IDX_W];

    ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(ENT_SHIFT)) u_l1_addr (
        .base(r_q.base), .idx(idx_hi), .addr(l1_addr)
    );

    ptw_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(ENT_SHIFT)) u_l2_addr (
        .base(r_q.l2_base), .idx(idx_lo), .addr(l2_addr)
    );

    ptw_entry_unpack #(.DATA_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_unpack (
        .entry(mem_rsp_data), .frame(rsp_frame), .flags(rsp_flags)
    );

    ptw_perm_check u_perm (
        .flags(rsp_flags), .acc(r_q.acc), .user(r_q.user), .allowed(perm_ok)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_L1_REQ;
                    r_d.va   = req_vaddr;
                    r_d.acc  = acc_kind_e'(req_acc);
                    r_d.user = req_user;
                    r_d.base = ptbr;
                end
            end
            ST_L1_REQ: if (mem_req_ready) r_d.st = ST_L1_WAIT;
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!rsp_flags.present) begin
                        r_d.st    = ST_FAULT;
                        r_d.fault = FLT_L1;
                        r_d.paddr = '0;
                    end else begin
                        r_d.st      = ST_L2_REQ;
                        r_d.l2_base = {rsp_frame, {PAGE_BITS{1'b0}}};
                    end
                end
            end
            ST_L2_REQ: if (mem_req_ready) r_d.st = ST_L2_WAIT;
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!rsp_flags.present) begin
                        r_d.st    = ST_FAULT;
                        r_d.fault = FLT_L2;
                        r_d.paddr = '0;
                    end else if (!perm_ok) begin
                        r_d.st    = ST_FAULT;
                        r_d.fault = FLT_PERM;
                        r_d.paddr = '0;
                    end else begin
                        r_d.st    = ST_DONE;
                        r_d.fault = FLT_NONE;
                        r_d.paddr = {rsp_frame, r_q.va[PAGE_BITS-1:0]};
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, acc: ACC_RD, fault: FLT_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_L1_REQ) || (r_q.st == ST_L2_REQ);
    assign mem_req_addr  = (r_q.st == ST_L2_REQ) ? l2_addr : l1_addr;
    assign done_valid    = (r_q.st == ST_DONE) || (r_q.st == ST_FAULT);
    assign done_paddr    = r_q.paddr;
    assign done_fault    = r_q.fault;

    // R9
    idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (mem_req_valid || done_valid)));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R3
    offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault == 2'd0) |-> (done_paddr[PAGE_BITS-1:0] == r_q.va[PAGE_BITS-1:0]));

    // R5
    l1_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_L1_WAIT && mem_rsp_valid && !mem_rsp_data[0])
        |=> (done_valid && done_fault == 2'd1 && !mem_req_valid));

    // R6
    l2_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_L2_WAIT && mem_rsp_valid && !mem_rsp_data[0])
        |=> (done_valid && done_fault == 2'd2));
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [31:0] ptbr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;

    always #10 clk = ~clk; // 50 MHz

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .ptbr(ptbr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
        .done_paddr(done_paddr), .done_fault(done_fault)
    );

    // memory model
    logic [31:0] mem [0:4095];
    logic        stall_mode = 1'b0;
    int          lat = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          lat_cnt = 0;
    int          n_acc = 0;
    int          n_l2 = 0;
    logic [31:0] acc_log [0:1];

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (lat_cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[pend_addr[13:2]];
                pend          <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            pend      <= 1'b1;
            pend_addr <= mem_req_addr;
            lat_cnt   <= lat;
            if (n_acc < 2) acc_log[n_acc] <= mem_req_addr;
            n_acc     <= n_acc + 1;
            if (mem_req_addr >= 32'h1000 && mem_req_addr < 32'h3000) n_l2 <= n_l2 + 1;
        end
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
    end

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr,
                        input logic busy_noise,
                        output logic [31:0] pa, output logic [1:0] flt);
        int waited;
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
        n_acc = 0;
        @(negedge clk);
        if (busy_noise) begin
            req_vaddr = 32'h0040_0000; req_acc = 2'd3; req_user = 1'b1;
            for (int k = 0; k < 3; k++) begin
                chk("R9 ready low while busy", {31'd0, req_ready}, 32'd0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        waited = 0;
        while (!done_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        pa = done_paddr; flt = done_fault;
        chk("R3 done seen", {31'd0, done_valid}, 32'd1);
        @(negedge clk);
        chk("R3 done one cycle", {31'd0, done_valid}, 32'd0);
    endtask

    // {vaddr, acc, user, fault, paddr}
    localparam int NV = 12;
    localparam logic [68:0] VEC [NV] = '{
        {32'h0000_0ABC, 2'd0, 1'b1, 2'd0, 32'h1234_5ABC}, // R3 R4 read
        {32'h0000_0123, 2'd2, 1'b1, 2'd0, 32'h1234_5123}, // R7 exec
        {32'h0000_0004, 2'd1, 1'b1, 2'd3, 32'h0000_0000}, // R7 no write bit
        {32'h0000_1FFF, 2'd1, 1'b1, 2'd0, 32'hABCD_EFFF}, // R7 write
        {32'h0000_1000, 2'd2, 1'b0, 2'd3, 32'h0000_0000}, // R7 no exec bit
        {32'h0000_2010, 2'd0, 1'b1, 2'd2, 32'h0000_0000}, // R6 absent beats perm
        {32'h0000_3456, 2'd0, 1'b1, 2'd3, 32'h0000_0000}, // R8 user on sup page
        {32'h0000_3456, 2'd0, 1'b0, 2'd0, 32'h0F0F_0456}, // R8 supervisor ok
        {32'h007F_FFFF, 2'd1, 1'b0, 2'd0, 32'hFFFF_FFFF}, // R2 last index
        {32'h0080_0000, 2'd0, 1'b0, 2'd1, 32'h0000_0000}, // R5
        {32'hFFC0_0000, 2'd2, 1'b0, 2'd1, 32'h0000_0000}, // R5 last L1 index
        {32'h0000_0000, 2'd3, 1'b0, 2'd3, 32'h0000_0000}  // R7 reserved kind
    };

    initial begin
        logic [31:0] pa;
        logic [1:0]  flt;
        int          l2_before;
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        mem[0]              = 32'h0000_1001;  // L1[0] -> table A
        mem[1]              = 32'h0000_2001;  // L1[1] -> table B
        mem[1024 + 0]       = 32'h1234_500B;  // P R X
        mem[1024 + 1]       = 32'hABCD_E007;  // P R W
        mem[1024 + 2]       = 32'h5555_5012;  // absent, sup, R
        mem[1024 + 3]       = 32'h0F0F_0017;  // P R W sup
        mem[2048 + 0]       = 32'h0077_700F;  // P R W X
        mem[2048 + 1023]    = 32'hFFFF_F00F;  // P R W X
        mem[3072 + 1]       = 32'h0000_2001;  // second root: L1[1] -> table B

        repeat (3) @(negedge clk);
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        chk("R1 done_valid", {31'd0, done_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int pass = 0; pass < 2; pass++) begin
            stall_mode = (pass == 1);  // R10 second pass with stalls and delay
            lat = (pass == 1) ? 3 : 0;
            for (int v = 0; v < NV; v++) begin
                l2_before = n_l2;
                walk(VEC[v][68:37], VEC[v][36:35], VEC[v][34], 1'b0, pa, flt);
                chk($sformatf("R10 pass%0d vec%0d fault", pass, v), {30'd0, flt}, {30'd0, VEC[v][33:32]});
                chk($sformatf("R3 pass%0d vec%0d paddr", pass, v), pa, VEC[v][31:0]);
                if (VEC[v][33:32] == 2'd1)
                    chk("R5 no second read", n_l2, l2_before);
            end
        end

        // R2: alternate root, check both read addresses
        ptbr = 32'h0000_3000;
        stall_mode = 1'b0; lat = 1;
        walk(32'h0040_0ABC, 2'd0, 1'b1, 1'b0, pa, flt);
        chk("R2 first read address", acc_log[0], 32'h0000_3004);
        chk("R2 second read address", acc_log[1], 32'h0000_2000);
        chk("R2 paddr via new root", pa, 32'h0077_7ABC);

        // R9: request noise during a walk is ignored
        ptbr = 32'h0000_0000; lat = 3;
        walk(32'h0000_1234, 2'd1, 1'b1, 1'b1, pa, flt);
        chk("R9 fault unaffected", {30'd0, flt}, 32'd0);
        chk("R9 paddr unaffected", pa, 32'hABCD_E234);
        chk("R9 idle after walk", {31'd0, req_ready}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule